// File: doc/BRIEF.md
# Multi-Channel Down-Counting Interval Timer

This block is a register-mapped timer peripheral holding a parameterised number of independent down-counters (two by default) behind one shared 32-bit register window. Each channel has a control word, an interval (reload) value and a readable live count. A channel advances only on tick-enable pulses. Its control word picks one of four incoming tick sources and a power-of-two prescaler. The channel runs either periodically, reloading its interval after each expiry, or once, stopping itself at zero.

When a count steps from one to zero, the channel latches a pending bit in a shared status register. Software clears that bit by writing a one to it. A pending bit whose matching mask bit is set drives the single interrupt line. Clearing a channel's enable does not stop it at once: it keeps stepping for a short drain of channel ticks, and software must wait before it reprograms the channel. An interval of all ones in periodic mode gives a free-running counter whose bitwise complement serves as a rising timestamp.

Top module: `ivtimer`

## Requirements
- R1: After reset every register reads as zero and `irq` is low, so every channel is stopped and masked.
- R2: The register map is as follows. Offset 0x00 is the interrupt mask, where bit n belongs to channel n and unused bits read 0. Offset 0x04 is the pending status. For channel n, the control word is at 0x10*n+0x10, the interval at 0x10*n+0x14 and the live count at 0x10*n+0x18. Reads of any other offset return zero. The mask and the interval read back as written. Control bit 1 (reload) always reads 0.
- R3: The control word has enable at bit 0, reload at bit 1, the source select at bits 3:2, the prescaler code at bits 6:4 and one-shot at bit 7. A control write with both enable and reload set copies the interval into the count. A control write with only enable set leaves the count as it was.
- R4: A running channel decrements its count by one per channel tick. With source s and prescaler code p, a channel tick is every 2^p-th pulse on `src_tick[s]`, counted from the last control write. Pulses on sources that are not selected have no effect.
- R5: A tick that takes the count from 1 to 0 sets the channel's status bit. In periodic mode (bit 7 = 0), the next tick at zero reloads the interval.
- R6: In one-shot mode (bit 7 = 1), expiry clears the channel's enable bit, so control bit 0 reads 0, and the count holds at zero through later pulses.
- R7: Writing 1 to a status bit clears it, and writing 0 has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R8: `irq` is high exactly when some channel has both its status bit and its mask bit set.
- R9: After a control write clears enable on a running channel, the channel still takes up to 2 further channel ticks and then stops. A later write that sets enable resumes counting from the held value.
- R10: Writes to a count register or to an unmapped offset change no register.
- R11: In periodic mode with an interval of all ones, the count wraps from 0 to 0xFFFFFFFF and then keeps counting down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 4 | Tick-enable pulses, one per selectable source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW (8) | Byte offset of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt: OR over channels of status AND mask |

## Verification
A register write takes effect at the first rising edge after its strobe. The read port is combinational, so any register's new value shows on `bus_rdata` in the same low clock phase in which the bench next presents the offset. A tick pulse held for one cycle changes the count, the status bit and `irq` at that same rising edge. The bench therefore drives all inputs at falling edges and samples one time unit after a falling edge, at least one full edge after the stimulus. Prescaler and drain counts are checked as whole numbers of pulses, never as wall-clock time.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   // control word layout; positions are visible to software
   localparam int CTL_W   = 8;
   localparam int SRC_W   = 2;
   localparam int PRE_W   = 3;
   localparam int NSRC    = 1 << SRC_W;

   // register offsets
   localparam int OFS_MASK   = 'h00;
   localparam int OFS_STAT   = 'h04;
   localparam int CH_STRIDE  = 'h10;
   localparam int CH_FIRST   = 'h10;
   localparam int OFS_CTRL   = 'h0;
   localparam int OFS_IVAL   = 'h4;
   localparam int OFS_COUNT  = 'h8;

   typedef struct packed {
      logic             one_shot;  // bit 7
      logic [PRE_W-1:0] pre;       // bits 6:4
      logic [SRC_W-1:0] src;       // bits 3:2
      logic             reload;    // bit 1
      logic             en;        // bit 0
   } ctrl_t;

   function automatic int chan_base(input int idx);
      return CH_FIRST + CH_STRIDE * idx;
   endfunction
endpackage

// File: rtl/ivt_prescale.sv
module ivt_prescale #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             src_pulse,
   input  logic [PRE_W-1:0] pre_code,
   output logic             tick
);
   localparam int PCNT_W = (1 << PRE_W) - 1;

   generate
      if (PRE_W == 0) begin : g_direct
         assign tick = src_pulse;
      end else begin : g_divide
         logic [PCNT_W-1:0] pcnt_q;
         logic [PCNT_W-1:0] pmask;

         always_comb begin
            pmask = '0;
            for (int b = 0; b < PCNT_W; b++) begin
               if (b < int'(pre_code)) pmask[b] = 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
               pcnt_q <= '0;
            end else if (src_pulse) begin
               pcnt_q <= pcnt_q + 1'b1;
            end
         end

         assign tick = src_pulse && ((pcnt_q & pmask) == pmask);
      end
   endgenerate
endmodule

// File: rtl/ivt_chan.sv
module ivt_chan #(
   parameter int CW          = 32,
   parameter int DRAIN_TICKS = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ivt_pkg::NSRC-1:0] src_tick,
   input  logic                   ctrl_we,
   input  ivt_pkg::ctrl_t         ctrl_wdata,
   input  logic                   ival_we,
   input  logic [CW-1:0]          ival_wdata,
   output logic [ivt_pkg::CTL_W-1:0] ctrl_rd,
   output logic [CW-1:0]          ival_q,
   output logic [CW-1:0]          cnt_q,
   output logic                   expire,
   output logic                   en_q,
   output logic                   one_shot,
   output logic                   running
);
   import ivt_pkg::*;

   localparam int DRW = $clog2(DRAIN_TICKS + 1);
   localparam logic [DRW-1:0] DRAIN_INIT = DRW'(DRAIN_TICKS);
   localparam logic [CW-1:0]  ONE        = CW'(1);

   ctrl_t          cfg_q, cfg_d;
   logic           en_d;
   logic [CW-1:0]  cnt_d, ival_d;
   logic [DRW-1:0] drain_q, drain_d;
   logic           ptick;

   ivt_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctrl_we),
      .src_pulse (src_tick[cfg_q.src]),
      .pre_code  (cfg_q.pre),
      .tick      (ptick)
   );

   assign running  = en_q || (drain_q != '0);
   assign one_shot = cfg_q.one_shot;

   always_comb begin
      cfg_d   = cfg_q;
      en_d    = en_q;
      cnt_d   = cnt_q;
      ival_d  = ival_q;
      drain_d = drain_q;
      expire  = 1'b0;

      if (ival_we) ival_d = ival_wdata;

      if (ctrl_we) begin
         cfg_d        = ctrl_wdata;
         cfg_d.reload = 1'b0;
         cfg_d.en     = 1'b0;
         en_d         = ctrl_wdata.en;
         if (ctrl_wdata.en) begin
            drain_d = '0;
            if (ctrl_wdata.reload) cnt_d = ival_q;
         end else if (en_q) begin
            drain_d = DRAIN_INIT;
         end
      end else if (running && ptick) begin
         if (!en_q) drain_d = drain_q - 1'b1;
         if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
            if (cnt_q == ONE) begin
               expire = 1'b1;
               if (cfg_q.one_shot) begin
                  en_d    = 1'b0;
                  drain_d = '0;
               end
            end
         end else if (cfg_q.one_shot) begin
            en_d    = 1'b0;
            drain_d = '0;
         end else begin
            cnt_d = ival_q;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= '0;
         en_q    <= 1'b0;
         cnt_q   <= '0;
         ival_q  <= '0;
         drain_q <= '0;
      end else begin
         cfg_q   <= cfg_d;
         en_q    <= en_d;
         cnt_q   <= cnt_d;
         ival_q  <= ival_d;
         drain_q <= drain_d;
      end
   end

   always_comb begin
      ctrl_rd    = cfg_q;
      ctrl_rd[0] = en_q;
      ctrl_rd[1] = 1'b0;
   end
endmodule

// File: rtl/ivtimer.sv
module ivtimer #(
   parameter int NCH         = 2,
   parameter int CW          = 32,
   parameter int DW          = 32,
   parameter int AW          = 8,
   parameter int DRAIN_TICKS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ivt_pkg::NSRC-1:0] src_tick,
   input  logic                     bus_wr,
   input  logic [AW-1:0]            bus_addr,
   input  logic [DW-1:0]            bus_wdata,
   output logic [DW-1:0]            bus_rdata,
   output logic                     irq
);
   import ivt_pkg::*;

   localparam int TOP_OFS = CH_FIRST + CH_STRIDE * (NCH - 1) + OFS_COUNT;

   generate
      if (NCH < 1 || NCH > DW) begin : g_bad_nch
         $error("ivtimer: NCH must be between 1 and DW");
      end
      if (CW < 2 || CW > DW) begin : g_bad_cw
         $error("ivtimer: CW must be between 2 and DW");
      end
      if (DW < CTL_W) begin : g_bad_dw
         $error("ivtimer: DW too narrow for the control word");
      end
      if (TOP_OFS >= (1 << AW)) begin : g_bad_aw
         $error("ivtimer: AW too narrow for the register map");
      end
      if (DRAIN_TICKS < 1) begin : g_bad_drain
         $error("ivtimer: DRAIN_TICKS must be at least 1");
      end
   endgenerate

   logic [NCH-1:0]            ie_q, status_q, status_d;
   logic [NCH-1:0]            ch_exp, ch_en, ch_os, ch_run, ch_cw, ch_iw;
   logic [NCH-1:0][CTL_W-1:0] ch_ctrl;
   logic [NCH-1:0][CW-1:0]    ch_ival, ch_cnt;
   logic                      wr_mask, wr_stat;
   logic                      unused_wdata;

   assign unused_wdata = ^bus_wdata;
   assign wr_mask = bus_wr && (bus_addr == AW'(OFS_MASK));
   assign wr_stat = bus_wr && (bus_addr == AW'(OFS_STAT));

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      assign ch_cw[i] = bus_wr && (bus_addr == AW'(chan_base(i) + OFS_CTRL));
      assign ch_iw[i] = bus_wr && (bus_addr == AW'(chan_base(i) + OFS_IVAL));

      ivt_chan #(.CW(CW), .DRAIN_TICKS(DRAIN_TICKS)) u_chan (
         .clk        (clk),
         .rst_n      (rst_n),
         .src_tick   (src_tick),
         .ctrl_we    (ch_cw[i]),
         .ctrl_wdata (ctrl_t'(bus_wdata[CTL_W-1:0])),
         .ival_we    (ch_iw[i]),
         .ival_wdata (bus_wdata[CW-1:0]),
         .ctrl_rd    (ch_ctrl[i]),
         .ival_q     (ch_ival[i]),
         .cnt_q      (ch_cnt[i]),
         .expire     (ch_exp[i]),
         .en_q       (ch_en[i]),
         .one_shot   (ch_os[i]),
         .running    (ch_run[i])
      );
   end

   always_comb begin
      status_d = status_q;
      if (wr_stat) status_d = status_q & ~bus_wdata[NCH-1:0];
      status_d = status_d | ch_exp;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q     <= '0;
         status_q <= '0;
      end else begin
         if (wr_mask) ie_q <= bus_wdata[NCH-1:0];
         status_q <= status_d;
      end
   end

   assign irq = |(status_q & ie_q);

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == AW'(OFS_MASK)) bus_rdata = DW'(ie_q);
      if (bus_addr == AW'(OFS_STAT)) bus_rdata = DW'(status_q);
      for (int i = 0; i < NCH; i++) begin
         if (bus_addr == AW'(chan_base(i) + OFS_CTRL))  bus_rdata = DW'(ch_ctrl[i]);
         if (bus_addr == AW'(chan_base(i) + OFS_IVAL))  bus_rdata = DW'(ch_ival[i]);
         if (bus_addr == AW'(chan_base(i) + OFS_COUNT)) bus_rdata = DW'(ch_cnt[i]);
      end
   end
endmodule

module ivtimer_chk #(
   parameter int NCH = 2,
   parameter int CW  = 32,
   parameter int DW  = 32,
   parameter int AW  = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_wr,
   input logic [AW-1:0]         bus_addr,
   input logic [DW-1:0]         bus_wdata,
   input logic                  irq,
   input logic [NCH-1:0]        ie_q,
   input logic [NCH-1:0]        status_q,
   input logic [NCH-1:0]        ch_exp,
   input logic [NCH-1:0]        ch_en,
   input logic [NCH-1:0]        ch_os,
   input logic [NCH-1:0]        ch_run,
   input logic [NCH-1:0]        ch_cw,
   input logic [NCH-1:0][CW-1:0] ch_cnt
);
   logic unused_chk;
   assign unused_chk = ^bus_wdata;

   // R8
   no_status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q == '0) |-> !irq);

   // R8
   all_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q == '0) |-> !irq);

   for (genvar i = 0; i < NCH; i++) begin : g_p
      // R5
      expiry_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ch_exp[i] |=> status_q[i]);

      // R6
      oneshot_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ch_exp[i] && ch_os[i]) |=> !ch_en[i]);

      // R7
      w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_wr && bus_addr == AW'(4) && bus_wdata[i] && !ch_exp[i]) |=> !status_q[i]);

      // R4
      single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_cw[i] && ch_cnt[i] != '0) |=>
            (ch_cnt[i] == $past(ch_cnt[i]) || ch_cnt[i] == $past(ch_cnt[i]) - CW'(1)));

      // R9
      stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!ch_run[i] && !ch_cw[i]) |=> $stable(ch_cnt[i]));
   end
endmodule

bind ivtimer ivtimer_chk #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .ie_q      (ie_q),
   .status_q  (status_q),
   .ch_exp    (ch_exp),
   .ch_en     (ch_en),
   .ch_os     (ch_os),
   .ch_run    (ch_run),
   .ch_cw     (ch_cw),
   .ch_cnt    (ch_cnt)
);

// File: tb/ivtimer_bench.sv
module ivtimer_bench;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 100000;
   localparam int NVEC       = 6;
   // [31:30] source, [29:27] prescaler code, [26:16] pulses, [15:0] expected decrement
   localparam logic [31:0] VEC [NVEC] = '{
      {2'd0, 3'd0, 11'd5,   16'd5},
      {2'd1, 3'd1, 11'd5,   16'd2},
      {2'd2, 3'd2, 11'd9,   16'd2},
      {2'd3, 3'd3, 11'd17,  16'd2},
      {2'd0, 3'd7, 11'd300, 16'd2},
      {2'd2, 3'd0, 11'd0,   16'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src_tick = '0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   ivtimer u_ivtimer (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      check(tag, bus_rdata, exp);
   endtask

   task automatic irq_chk(input string tag, input logic exp);
      @(negedge clk);
      #1;
      check(tag, {31'd0, irq}, {31'd0, exp});
   endtask

   task automatic pulse(input int s, input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); src_tick[s] = 1'b1;
         @(negedge clk); src_tick[s] = 1'b0;
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_chk("R1 mask", 8'h00, 32'h0);
      rd_chk("R1 status", 8'h04, 32'h0);
      rd_chk("R1 ctrl0", 8'h10, 32'h0);
      rd_chk("R1 ival0", 8'h14, 32'h0);
      rd_chk("R1 count0", 8'h18, 32'h0);
      rd_chk("R1 ctrl1", 8'h20, 32'h0);
      irq_chk("R1 irq", 1'b0);

      // R2 map and readback
      wr(8'h00, 32'hFFFF_FFFF);
      rd_chk("R2 mask width", 8'h00, 32'h3);
      wr(8'h24, 32'h0000_ABCD);
      rd_chk("R2 ival1", 8'h24, 32'h0000_ABCD);
      wr(8'h20, 32'h0000_00FE);
      rd_chk("R2 ctrl1 reload reads 0", 8'h20, 32'h0000_00FC);
      rd_chk("R2 unmapped 08", 8'h08, 32'h0);
      rd_chk("R2 unmapped 1C", 8'h1C, 32'h0);
      rd_chk("R2 unmapped 40", 8'h40, 32'h0);

      // R3 load on enable with reload
      wr(8'h14, 32'd10);
      wr(8'h10, 32'h01);
      rd_chk("R3 enable only keeps count", 8'h18, 32'd0);
      wr(8'h10, 32'h03);
      rd_chk("R3 enable+reload loads", 8'h18, 32'd10);
      wr(8'h14, 32'd20);
      rd_chk("R3 interval write leaves count", 8'h18, 32'd10);

      // R4 source and prescaler table
      for (int v = 0; v < NVEC; v++) begin
         int s, p, n, e;
         s = int'(VEC[v][31:30]);
         p = int'(VEC[v][29:27]);
         n = int'(VEC[v][26:16]);
         e = int'(VEC[v][15:0]);
         wr(8'h14, 32'd1000);
         wr(8'h10, 32'h03 | (s << 2) | (p << 4));
         pulse(s, n);
         pulse((s + 1) % 4, 3);
         rd_chk($sformatf("R4 vector %0d", v), 8'h18, 32'd1000 - e);
      end

      // R5 / R7 / R8 periodic expiry, W1C, mask
      wr(8'h14, 32'd3);
      wr(8'h10, 32'h03);
      pulse(0, 2);
      rd_chk("R5 count before expiry", 8'h18, 32'd1);
      rd_chk("R5 no status yet", 8'h04, 32'h0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h1; src_tick[0] = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; src_tick[0] = 1'b0;
      rd_chk("R7 set wins over clear", 8'h04, 32'h1);
      rd_chk("R5 count at zero", 8'h18, 32'd0);
      irq_chk("R8 irq raised", 1'b1);
      pulse(0, 1);
      rd_chk("R5 periodic reload", 8'h18, 32'd3);
      wr(8'h04, 32'h0);
      rd_chk("R7 writing zero no effect", 8'h04, 32'h1);
      wr(8'h00, 32'h2);
      irq_chk("R8 masked", 1'b0);
      wr(8'h00, 32'h1);
      irq_chk("R8 unmasked", 1'b1);
      wr(8'h04, 32'h1);
      rd_chk("R7 cleared", 8'h04, 32'h0);
      irq_chk("R8 irq drops after clear", 1'b0);

      // R6 one-shot on channel 1, source 1
      wr(8'h24, 32'd2);
      wr(8'h20, 32'h87);
      rd_chk("R6 loaded", 8'h28, 32'd2);
      pulse(1, 2);
      rd_chk("R6 count zero", 8'h28, 32'd0);
      rd_chk("R6 status bit1", 8'h04, 32'h2);
      rd_chk("R6 enable cleared", 8'h20, 32'h84);
      irq_chk("R8 bit1 masked", 1'b0);
      pulse(1, 2);
      rd_chk("R6 holds zero", 8'h28, 32'd0);
      wr(8'h04, 32'h2);

      // R9 disable drain
      wr(8'h14, 32'd100);
      wr(8'h10, 32'h03);
      pulse(0, 5);
      rd_chk("R9 running", 8'h18, 32'd95);
      wr(8'h10, 32'h00);
      pulse(0, 5);
      rd_chk("R9 two drain ticks", 8'h18, 32'd93);
      wr(8'h10, 32'h01);
      pulse(0, 2);
      rd_chk("R9 resume from held", 8'h18, 32'd91);

      // R10 ignored writes
      wr(8'h18, 32'h55);
      rd_chk("R10 count write ignored", 8'h18, 32'd91);
      wr(8'h0C, 32'h0);
      rd_chk("R10 unmapped write mask", 8'h00, 32'h1);
      rd_chk("R10 unmapped write ival0", 8'h14, 32'd100);

      // R11 wrap to all ones
      wr(8'h24, 32'd1);
      wr(8'h20, 32'h07);
      pulse(1, 1);
      rd_chk("R11 reached zero", 8'h28, 32'd0);
      wr(8'h24, 32'hFFFF_FFFF);
      pulse(1, 1);
      rd_chk("R11 wrapped", 8'h28, 32'hFFFF_FFFF);
      pulse(1, 1);
      rd_chk("R11 counts on", 8'h28, 32'hFFFF_FFFE);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule